// File: doc/BRIEF.md
# T1 Receive Frame Timing Generator

This block produces the receive-side timing markers for a 24-channel T1 stream at the 1.544 MHz line rate. It tracks where the current bit sits inside the 193-bit frame and which frame of the 12-frame multiframe is current. A frame is one framing bit followed by 24 channels of 8 bits. The block drives four outputs from that position: a per-channel gating output, a configurable sync pulse, a frame-sync pulse and a multiframe-sync pulse.

Frame search is done upstream. An upstream framer supplies an alignment strobe, and from that point the counters run freely. The per-channel gate can be programmed to be high or low for each channel. It is used to gate the clock of a serial controller that handles only some channels, or to mark channels for drop-and-insert work. Two configuration inputs set the sync output. It can mark frame boundaries or multiframe boundaries. In frame mode it can also be stretched to two bit periods on the signaling frames, which are frames 6 and 12.

The position tracker is a two-state machine. In state ST_FBIT the current bit is the framing bit. In state ST_CHAN the current bit belongs to a channel, and two sub-counters hold the channel index and the bit index within that channel. The machine has these transitions:
- ST_FBIT to ST_CHAN on every clock without a strobe.
- ST_CHAN to ST_CHAN while bits of the frame remain.
- ST_CHAN to ST_FBIT after the last bit of channel 23. This transition advances the frame number, and frame 12 wraps to frame 1.
- Any state to ST_FBIT, with the frame number set to 1, when the strobe is sampled.

All outputs are registers updated on the rising clock edge. They are decoded from the position that becomes current at that edge.

Top module: `t1_rx_timing`

## Requirements
- R1: While `rst_ni` is low, all four outputs are low.
- R2: `fsync_o` is high for exactly the one bit period of each framing bit and low for the other 192 periods of the frame.
- R3: When `align_i` is sampled high at a rising edge, the period that follows that edge is the framing bit of frame 1. In that period `fsync_o` and `msync_o` are both high. Counting continues from that position.
- R4: `msync_o` is high only during the framing bit of frame 1. This happens once every 12 frames, or 2316 periods.
- R5: `chan_gate_o` is low during every framing-bit period.
- R6: Channel c (c = 0..23) occupies the bit positions 1+8c through 8+8c after the framing bit. During those positions `chan_gate_o` equals the force bit of channel c. All force bits are 0 after reset.
- R7: A write (`cfg_we_i` high, with `cfg_ch_i` and `cfg_val_i`) sampled at edge E sets the force bit of channel `cfg_ch_i`. The new value appears on `chan_gate_o` from the period that starts at edge E+1. It does not appear in the period that starts at edge E.
- R8: A write whose `cfg_ch_i` is 24 to 31 changes no force bit.
- R9: With `sync_mf_sel_i` = 0 and `sync_wide_i` = 0, `sync_o` equals `fsync_o`. The configuration inputs are sampled at the same edge as the position they decode.
- R10: With `sync_mf_sel_i` = 0 and `sync_wide_i` = 1, in frames 6 and 12 `sync_o` is high for the framing bit and for position 1, which is two periods. In all other frames it is high for the framing bit only.
- R11: With `sync_mf_sel_i` = 1, `sync_o` equals `msync_o`, and `sync_wide_i` has no effect.
- R12: After reset is released, if no strobe arrives, the period after the first rising edge is the framing bit of frame 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| align_i | input | 1 | Alignment strobe: the next bit is the framing bit of frame 1 |
| sync_mf_sel_i | input | 1 | Sync output marks frames (0) or multiframes (1) |
| sync_wide_i | input | 1 | Stretch the frame-mode sync to two periods on signaling frames |
| cfg_we_i | input | 1 | Force-bit write enable |
| cfg_ch_i | input | 5 | Channel index for the write |
| cfg_val_i | input | 1 | Force value for the write |
| chan_gate_o | output | 1 | Per-channel forced level, low on the framing bit |
| sync_o | output | 1 | Configurable boundary pulse |
| fsync_o | output | 1 | Frame boundary pulse |
| msync_o | output | 1 | Multiframe boundary pulse |

## Verification
Every output is due in the period that starts at the edge where its cause is sampled. A strobe, a configuration level or a clock edge that moves the position shows up at that same edge. The one exception is a force-bit write, which reaches `chan_gate_o` one edge later. The bench updates its arithmetic model of position, frame number and force bits at each rising edge, following those rules exactly. It holds back each write until the following edge. It compares all four outputs at the falling edge, halfway through the period in which they are due.

// File: rtl/t1rt_pkg.sv
package t1rt_pkg;

    typedef enum logic [0:0] {
        ST_FBIT = 1'b0,
        ST_CHAN = 1'b1
    } seq_state_e;

endpackage

// File: rtl/t1rt_seq.sv
module t1rt_seq
    import t1rt_pkg::*;
#(
    parameter int NUM_CH     = 24,
    parameter int CH_BITS    = 8,
    parameter int NUM_FRAMES = 12,
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BW = (CH_BITS > 1) ? $clog2(CH_BITS) : 1,
    localparam int FW = $clog2(NUM_FRAMES + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          align_i,
    output logic          fbit_nxt_o,
    output logic          first_pay_nxt_o,
    output logic [CW-1:0] ch_nxt_o,
    output logic [FW-1:0] frm_nxt_o
);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] ch_q, ch_d;
    logic [BW-1:0] bit_q, bit_d;
    logic [FW-1:0] frm_q, frm_d;

    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        bit_d   = bit_q;
        frm_d   = frm_q;
        if (align_i) begin
            state_d = ST_FBIT;
            ch_d    = '0;
            bit_d   = '0;
            frm_d   = FW'(1);
        end else begin
            unique case (state_q)
                ST_FBIT: begin
                    state_d = ST_CHAN;
                    ch_d    = '0;
                    bit_d   = '0;
                end
                ST_CHAN: begin
                    if (bit_q == BW'(CH_BITS - 1)) begin
                        bit_d = '0;
                        if (ch_q == CW'(NUM_CH - 1)) begin
                            state_d = ST_FBIT;
                            ch_d    = '0;
                            frm_d   = (frm_q == FW'(NUM_FRAMES)) ? FW'(1) : frm_q + FW'(1);
                        end else begin
                            ch_d = ch_q + CW'(1);
                        end
                    end else begin
                        bit_d = bit_q + BW'(1);
                    end
                end
            endcase
        end
    end

    // Reset parks on the last bit of the last frame so the first edge opens frame 1.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_CHAN;
            ch_q    <= CW'(NUM_CH - 1);
            bit_q   <= BW'(CH_BITS - 1);
            frm_q   <= FW'(NUM_FRAMES);
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
            bit_q   <= bit_d;
            frm_q   <= frm_d;
        end
    end

    assign fbit_nxt_o      = (state_d == ST_FBIT);
    assign first_pay_nxt_o = (state_d == ST_CHAN) && (ch_d == '0) && (bit_d == '0);
    assign ch_nxt_o        = ch_d;
    assign frm_nxt_o       = frm_d;

endmodule

// File: rtl/t1rt_chan_mask.sv
module t1rt_chan_mask #(
    parameter int NUM_CH = 24,
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [CW-1:0] wr_ch_i,
    input  logic          wr_val_i,
    input  logic [CW-1:0] rd_ch_i,
    output logic          rd_bit_o
);

    logic [NUM_CH-1:0] force_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                force_q[c] <= 1'b0;
            end else if (we_i && (wr_ch_i == CW'(c))) begin
                force_q[c] <= wr_val_i;
            end
        end
    end

    always_comb begin
        rd_bit_o = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_ch_i == CW'(c)) rd_bit_o = force_q[c];
        end
    end

endmodule

// File: rtl/t1rt_out.sv
module t1rt_out #(
    parameter int NUM_FRAMES  = 12,
    parameter int SIG_FRAME_A = 6,
    parameter int SIG_FRAME_B = 12,
    localparam int FW = $clog2(NUM_FRAMES + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fbit_nxt_i,
    input  logic          first_pay_nxt_i,
    input  logic [FW-1:0] frm_nxt_i,
    input  logic          force_bit_i,
    input  logic          mf_sel_i,
    input  logic          wide_i,
    output logic          chan_gate_o,
    output logic          sync_o,
    output logic          fsync_o,
    output logic          msync_o
);

    logic sig_frame;
    logic msync_d;
    logic sync_d;

    always_comb begin
        sig_frame = (frm_nxt_i == FW'(SIG_FRAME_A)) || (frm_nxt_i == FW'(SIG_FRAME_B));
        msync_d   = fbit_nxt_i && (frm_nxt_i == FW'(1));
        sync_d    = mf_sel_i ? msync_d
                             : (fbit_nxt_i || (wide_i && first_pay_nxt_i && sig_frame));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chan_gate_o <= 1'b0;
            sync_o      <= 1'b0;
            fsync_o     <= 1'b0;
            msync_o     <= 1'b0;
        end else begin
            chan_gate_o <= fbit_nxt_i ? 1'b0 : force_bit_i;
            sync_o      <= sync_d;
            fsync_o     <= fbit_nxt_i;
            msync_o     <= msync_d;
        end
    end

endmodule

// File: rtl/t1_rx_timing.sv
module t1_rx_timing #(
    parameter int NUM_CH      = 24,
    parameter int CH_BITS     = 8,
    parameter int NUM_FRAMES  = 12,
    parameter int SIG_FRAME_A = 6,
    parameter int SIG_FRAME_B = 12,
    localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          align_i,
    input  logic          sync_mf_sel_i,
    input  logic          sync_wide_i,
    input  logic          cfg_we_i,
    input  logic [CW-1:0] cfg_ch_i,
    input  logic          cfg_val_i,
    output logic          chan_gate_o,
    output logic          sync_o,
    output logic          fsync_o,
    output logic          msync_o
);

    localparam int FW = $clog2(NUM_FRAMES + 1);

    logic          fbit_nxt;
    logic          first_pay_nxt;
    logic [CW-1:0] ch_nxt;
    logic [FW-1:0] frm_nxt;
    logic          force_bit;

    t1rt_seq #(
        .NUM_CH    (NUM_CH),
        .CH_BITS   (CH_BITS),
        .NUM_FRAMES(NUM_FRAMES)
    ) seq_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .align_i        (align_i),
        .fbit_nxt_o     (fbit_nxt),
        .first_pay_nxt_o(first_pay_nxt),
        .ch_nxt_o       (ch_nxt),
        .frm_nxt_o      (frm_nxt)
    );

    t1rt_chan_mask #(
        .NUM_CH(NUM_CH)
    ) mask_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .wr_ch_i (cfg_ch_i),
        .wr_val_i(cfg_val_i),
        .rd_ch_i (ch_nxt),
        .rd_bit_o(force_bit)
    );

    t1rt_out #(
        .NUM_FRAMES (NUM_FRAMES),
        .SIG_FRAME_A(SIG_FRAME_A),
        .SIG_FRAME_B(SIG_FRAME_B)
    ) out_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .fbit_nxt_i     (fbit_nxt),
        .first_pay_nxt_i(first_pay_nxt),
        .frm_nxt_i      (frm_nxt),
        .force_bit_i    (force_bit),
        .mf_sel_i       (sync_mf_sel_i),
        .wide_i         (sync_wide_i),
        .chan_gate_o    (chan_gate_o),
        .sync_o         (sync_o),
        .fsync_o        (fsync_o),
        .msync_o        (msync_o)
    );

endmodule

// File: rtl/t1_rx_timing_chk.sv
module t1_rx_timing_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic align_i,
    input logic sync_mf_sel_i,
    input logic sync_wide_i,
    input logic chan_gate_o,
    input logic sync_o,
    input logic fsync_o,
    input logic msync_o
);

    logic edge_seen;

    always_ff @(posedge clk_i) edge_seen <= 1'b1;

    // R1: outputs stay low while reset is held
    always @(negedge clk_i) begin
        if (edge_seen === 1'b1 && rst_ni === 1'b0) begin
            assert_reset_low_R1: assert (!chan_gate_o && !sync_o && !fsync_o && !msync_o);
        end
    end

    assert_fsync_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsync_o && !align_i) |=> !fsync_o);

    assert_align_marks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        align_i |=> (fsync_o && msync_o));

    assert_msync_on_fbit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msync_o |-> fsync_o);

    assert_gate_low_fbit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsync_o |-> !chan_gate_o);

    assert_narrow_sync_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(sync_mf_sel_i) && !$past(sync_wide_i)) |-> (sync_o == fsync_o));

    assert_wide_follows_fbit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(sync_mf_sel_i) && sync_o && !fsync_o) |-> $past(fsync_o));

    assert_mf_sync_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(sync_mf_sel_i) |-> (sync_o == msync_o));

endmodule

bind t1_rx_timing t1_rx_timing_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .align_i      (align_i),
    .sync_mf_sel_i(sync_mf_sel_i),
    .sync_wide_i  (sync_wide_i),
    .chan_gate_o  (chan_gate_o),
    .sync_o       (sync_o),
    .fsync_o      (fsync_o),
    .msync_o      (msync_o)
);

// File: tb/t1_rx_timing_tb_top.sv
module t1_rx_timing_tb_top;

    localparam int FRAME_BITS = 193;
    localparam int NFR        = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       align = 1'b0;
    logic       mf_sel = 1'b0;
    logic       wide = 1'b0;
    logic       we = 1'b0;
    logic [4:0] wch = '0;
    logic       wval = 1'b0;
    logic       gate, sync, fsync, msync;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    int m_pos = FRAME_BITS - 1;
    int m_frm = NFR;
    bit m_force [24];

    always #10 clk = ~clk;

    t1_rx_timing dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .align_i      (align),
        .sync_mf_sel_i(mf_sel),
        .sync_wide_i  (wide),
        .cfg_we_i     (we),
        .cfg_ch_i     (wch),
        .cfg_val_i    (wval),
        .chan_gate_o  (gate),
        .sync_o       (sync),
        .fsync_o      (fsync),
        .msync_o      (msync)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s pos=%0d frame=%0d actual=%0b expected=%0b",
                     req, what, m_pos, m_frm, act, exp);
        end
    endtask

    // one clock: model advances at the rising edge, outputs compared at the falling edge
    task automatic tick();
        bit e_gate, e_f, e_m, e_s;
        string sreq;
        @(posedge clk);
        if (rst_n) begin
            if (align) begin
                m_pos = 0;
                m_frm = 1;
            end else if (m_pos == FRAME_BITS - 1) begin
                m_pos = 0;
                m_frm = (m_frm == NFR) ? 1 : m_frm + 1;
            end else begin
                m_pos++;
            end
            e_gate = (m_pos == 0) ? 1'b0 : m_force[(m_pos - 1) / 8];
            e_f    = (m_pos == 0);
            e_m    = (m_pos == 0) && (m_frm == 1);
            if (mf_sel) begin
                e_s = e_m; sreq = "R11";
            end else if (wide) begin
                e_s = e_f || (m_pos == 1 && (m_frm == 6 || m_frm == 12)); sreq = "R10";
            end else begin
                e_s = e_f; sreq = "R9";
            end
            // R7/R8: write lands after this edge's decode; out-of-range index ignored
            if (we && wch < 24) m_force[wch] = wval;
        end
        @(negedge clk);
        if (!rst_n) begin
            check("R1", "gate",  gate,  1'b0);
            check("R1", "sync",  sync,  1'b0);
            check("R1", "fsync", fsync, 1'b0);
            check("R1", "msync", msync, 1'b0);
        end else begin
            check((m_pos == 0) ? "R5" : "R6_R7_R8", "gate", gate, e_gate);
            check((m_pos == 0 && align === 1'b0) ? "R2_R12" : "R2_R3", "fsync", fsync, e_f);
            check("R4_R3", "msync", msync, e_m);
            check(sreq, "sync", sync, e_s);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_ch(input int ch, input bit v);
        we = 1'b1; wch = 5'(ch); wval = v;
        tick();
        we = 1'b0;
    endtask

    task automatic pulse_align();
        align = 1'b1;
        tick();
        align = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] lfsr = 8'hA5;
        for (int c = 0; c < 24; c++) m_force[c] = 1'b0;
        run(4);                       // R1 under reset
        @(negedge clk);
        rst_n = 1'b1;
        run(3 * FRAME_BITS);          // R12 free run from reset, R6 all-zero force
        for (int c = 0; c < 24; c++) write_ch(c, (c % 3) == 0);   // R6 / R7
        for (int c = 24; c < 32; c++) write_ch(c, 1'b1);          // R8
        run(2 * FRAME_BITS);
        run(57);
        pulse_align();                // R3 mid-frame
        run(13 * FRAME_BITS);         // R9, R2, R4
        wide = 1'b1;
        run(13 * FRAME_BITS);         // R10
        mf_sel = 1'b1;
        run(13 * FRAME_BITS);         // R11 with wide set
        wide = 1'b0;
        run(2 * FRAME_BITS);          // R11 without wide
        mf_sel = 1'b0;
        wide = 1'b1;
        // R7: rewrites while channels are live
        for (int k = 0; k < 3 * FRAME_BITS; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (k % 5 == 0) write_ch(lfsr[4:0], lfsr[7]);
            else tick();
        end
        for (int c = 0; c < 24; c++) write_ch(c, (c % 2) == 1);
        pulse_align();
        pulse_align();                // back-to-back strobes, R3
        run(100);
        pulse_align();
        run(12 * FRAME_BITS + 10);
        summary();
    end

endmodule